// File: doc/BRIEF.md
# Chained Acquisition Frame Relay Node

This block is one link in a string of acquisition boards that share a single serial frame stream. The stream arrives as single bits, each marked by a valid strobe. A frame is a start bit of value 1, then a payload of upstream bits, then stop bits of value 0. Each incoming frame start also serves as the board's sampling event. The node sends a trigger pulse to its local sampler, passes the upstream payload through unchanged and one cycle late, and then adds its own sample word before new stop bits. The word it adds is the conversion result that has been waiting since the previous frame. Each node therefore lengthens the frame by one sample word, and the next node down is built with a payload length to match.

A static strap input picks the node's role. In relay mode the node follows the incoming stream. In head-of-chain mode it ignores the serial input and makes frames itself. A programmable divider of the symbol clock starts one frame every `frame_period` cycles. Each such frame carries only the start bit, the local sample and the stop bits. If a new frame start arrives while the outgoing frame is still being sent, the node drops the rest of that frame, flags an overrun and begins the new frame at once.

Top module: `chain_node`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `smp_trig` and `overrun` are low.
- R2: In relay mode (`master_sel`=0), a valid input bit of value 1 is a frame start if it arrives while the node is hunting for one. One clock edge later the node outputs a start bit (`out_valid`=1, `out_bit`=1) and pulses `smp_trig` in that same cycle.
- R3: In relay mode, the UP_W payload bits after the start bit are copied to the output in the order they arrive. Each appears exactly one cycle after the input cycle that carried it. Cycles with `in_valid` low inside the payload give output cycles with `out_valid` low.
- R4: Right after the last forwarded payload bit, the node outputs its SAMPLE_W sample bits on consecutive cycles, most significant bit first. It then outputs STOP_N zero bits, and after that `out_valid` goes low.
- R5: In relay mode, the STOP_N input slots after the payload are consumed whatever their value, and none of them starts a frame. Input bits with `in_valid` low are ignored. Valid zero bits are ignored while the node is hunting.
- R6: The sample word sent in a frame is the value of `smp_data` in the cycle the frame start is taken. This is the conversion result from the previous trigger. Later changes to `smp_data` do not change that frame.
- R7: In head-of-chain mode the serial input has no effect. A start bit is sent once every `frame_period` clock cycles. It is followed by the sample (MSB first) and STOP_N zero bits.
- R8: A frame start taken before the outgoing frame's last stop bit has been sent raises `overrun` for one cycle, together with the new start bit. The unsent remainder of the old frame is dropped.
- R9: `smp_trig` pulses exactly once for every frame start, in both modes, and always in the cycle that carries the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | Strap: 1 = head of chain, 0 = relay |
| frame_period | input | PERIOD_W | Frame spacing in clock cycles, head-of-chain mode |
| in_valid | input | 1 | Incoming bit strobe |
| in_bit | input | 1 | Incoming serial bit |
| smp_data | input | SAMPLE_W | Completed sample from the local sampler |
| smp_trig | output | 1 | One-cycle pulse to start the next local conversion |
| out_valid | output | 1 | Outgoing bit strobe |
| out_bit | output | 1 | Outgoing serial bit |
| overrun | output | 1 | One-cycle pulse when a frame was cut short |

## Verification
The relay path gets random payloads with random idle cycles inside them, and random values in the input stop slots. This separates strict one-cycle forwarding and a correct payload count from a node that would react to stop bits or lose its place across gaps. Directed frames use all-ones and all-zeros payloads and samples, to show that the append comes from the sample that was held and not from the payload. Each frame changes `smp_data` after its start, which shows the one-frame latch. In a back-to-back frame pair the second start lands in the middle of the append, so the exact truncated bit stream and the overrun pulse can be checked. Head-of-chain runs feed noise on the serial input. One uses a slow period and checks frame content and spacing. The other uses a period shorter than a frame and expects an overrun on every frame start after the first.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_PAY  = 2'd1,
    RX_STOP = 2'd2
  } rx_state_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_FWD  = 2'd1,
    TX_APP  = 2'd2,
    TX_STP  = 2'd3
  } tx_state_t;

endpackage

// File: rtl/cn_rx_framer.sv
module cn_rx_framer
  import chain_node_pkg::*;
#(
  parameter int UP_W   = 16,
  parameter int STOP_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic in_valid,
  input  logic in_bit,
  output logic start_o,
  output logic fwd_valid_o,
  output logic fwd_bit_o,
  output logic fwd_last_o
);

  localparam int PC_W = (UP_W < 2) ? 1 : $clog2(UP_W);
  localparam int SC_W = (STOP_N < 2) ? 1 : $clog2(STOP_N);

  rx_state_t        state;
  logic [PC_W-1:0]  pay_cnt;
  logic [SC_W-1:0]  stop_cnt;

  // start and payload qualifiers decoded from the current phase
  always_comb begin
    start_o     = enable && (state == RX_HUNT) && in_valid && in_bit;
    fwd_valid_o = enable && (state == RX_PAY) && in_valid;
    fwd_bit_o   = in_bit;
    fwd_last_o  = fwd_valid_o && (pay_cnt == PC_W'(UP_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state    <= RX_HUNT;
      pay_cnt  <= '0;
      stop_cnt <= '0;
    end else begin
      unique case (state)
        RX_HUNT: begin
          if (start_o) begin
            state   <= RX_PAY;
            pay_cnt <= '0;
          end
        end
        RX_PAY: begin
          if (in_valid) begin
            if (fwd_last_o) begin
              stop_cnt <= '0;
              state    <= (STOP_N > 0) ? RX_STOP : RX_HUNT;
            end else begin
              pay_cnt <= pay_cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (in_valid) begin
            if (stop_cnt == SC_W'(STOP_N - 1)) begin
              state <= RX_HUNT;
            end else begin
              stop_cnt <= stop_cnt + 1'b1;
            end
          end
        end
        default: state <= RX_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/cn_frame_timer.sv
module cn_frame_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick_o
);

  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W:0]   cnt_next;

  always_comb begin
    cnt_next = {1'b0, cnt} + 1'b1;
    tick_o   = enable && (cnt_next >= {1'b0, period});
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
    end else if (tick_o) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_next[PERIOD_W-1:0];
    end
  end

endmodule

// File: rtl/cn_tx_stream.sv
module cn_tx_stream
  import chain_node_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int STOP_N   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                direct_app_i,
  input  logic                fwd_valid_i,
  input  logic                fwd_bit_i,
  input  logic                fwd_last_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                out_valid_o,
  output logic                out_bit_o,
  output logic                trig_o,
  output logic                overrun_o
);

  localparam int AC_W = (SAMPLE_W < 2) ? 1 : $clog2(SAMPLE_W);
  localparam int SC_W = (STOP_N < 2) ? 1 : $clog2(STOP_N);

  tx_state_t           state;
  logic [SAMPLE_W-1:0] shreg;
  logic [AC_W-1:0]     app_cnt;
  logic [SC_W-1:0]     stp_cnt;
  logic                busy;

  assign busy = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= TX_IDLE;
      shreg       <= '0;
      app_cnt     <= '0;
      stp_cnt     <= '0;
      out_valid_o <= 1'b0;
      out_bit_o   <= 1'b0;
      trig_o      <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      out_bit_o   <= 1'b0;
      trig_o      <= 1'b0;
      overrun_o   <= 1'b0;
      if (start_i) begin
        // new frame wins over any unfinished one
        out_valid_o <= 1'b1;
        out_bit_o   <= 1'b1;
        trig_o      <= 1'b1;
        overrun_o   <= busy;
        shreg       <= sample_i;
        app_cnt     <= '0;
        stp_cnt     <= '0;
        state       <= direct_app_i ? TX_APP : TX_FWD;
      end else begin
        unique case (state)
          TX_IDLE: ;
          TX_FWD: begin
            if (fwd_valid_i) begin
              out_valid_o <= 1'b1;
              out_bit_o   <= fwd_bit_i;
              if (fwd_last_i) begin
                app_cnt <= '0;
                state   <= TX_APP;
              end
            end
          end
          TX_APP: begin
            out_valid_o <= 1'b1;
            out_bit_o   <= shreg[SAMPLE_W-1];
            shreg       <= shreg << 1;
            if (app_cnt == AC_W'(SAMPLE_W - 1)) begin
              stp_cnt <= '0;
              state   <= (STOP_N > 0) ? TX_STP : TX_IDLE;
            end else begin
              app_cnt <= app_cnt + 1'b1;
            end
          end
          TX_STP: begin
            out_valid_o <= 1'b1;
            out_bit_o   <= 1'b0;
            if (stp_cnt == SC_W'(STOP_N - 1)) begin
              state <= TX_IDLE;
            end else begin
              stp_cnt <= stp_cnt + 1'b1;
            end
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/chain_node.sv
module chain_node #(
  parameter int UP_W     = 16,
  parameter int SAMPLE_W = 8,
  parameter int STOP_N   = 2,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_sel,
  input  logic [PERIOD_W-1:0] frame_period,
  input  logic                in_valid,
  input  logic                in_bit,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_trig,
  output logic                out_valid,
  output logic                out_bit,
  output logic                overrun
);

  logic rx_start, fwd_valid, fwd_bit, fwd_last;
  logic tmr_tick, frame_start;

  cn_rx_framer #(
    .UP_W   (UP_W),
    .STOP_N (STOP_N)
  ) u_rx (
    .clk         (clk),
    .rst         (rst),
    .enable      (!master_sel),
    .in_valid    (in_valid),
    .in_bit      (in_bit),
    .start_o     (rx_start),
    .fwd_valid_o (fwd_valid),
    .fwd_bit_o   (fwd_bit),
    .fwd_last_o  (fwd_last)
  );

  cn_frame_timer #(
    .PERIOD_W (PERIOD_W)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .enable (master_sel),
    .period (frame_period),
    .tick_o (tmr_tick)
  );

  assign frame_start = master_sel ? tmr_tick : rx_start;

  cn_tx_stream #(
    .SAMPLE_W (SAMPLE_W),
    .STOP_N   (STOP_N)
  ) u_tx (
    .clk          (clk),
    .rst          (rst),
    .start_i      (frame_start),
    .direct_app_i (master_sel),
    .fwd_valid_i  (fwd_valid),
    .fwd_bit_i    (fwd_bit),
    .fwd_last_i   (fwd_last),
    .sample_i     (smp_data),
    .out_valid_o  (out_valid),
    .out_bit_o    (out_bit),
    .trig_o       (smp_trig),
    .overrun_o    (overrun)
  );

endmodule

// File: rtl/chain_node_chk.sv
module chain_node_chk #(
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                master_sel,
  input logic [PERIOD_W-1:0] frame_period,
  input logic                in_valid,
  input logic                in_bit,
  input logic                smp_trig,
  input logic                out_valid,
  input logic                out_bit,
  input logic                overrun
);

  logic [31:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (smp_trig) begin
      gap  <= 32'd1;
      seen <= 1'b1;
    end else if (gap != 32'hFFFF_FFFF) begin
      gap <= gap + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !smp_trig && !overrun));

  // R9
  trig_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    smp_trig |-> (out_valid && out_bit));

  // R8
  overrun_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> smp_trig);

  // R2
  relay_start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_trig && !master_sel) |-> ($past(in_valid) && $past(in_bit)));

  // R7
  head_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (master_sel && smp_trig && seen && frame_period != '0) |-> (gap == 32'(frame_period)));

  // R7
  head_append_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (master_sel && smp_trig) |=> out_valid);

endmodule

bind chain_node chain_node_chk #(
  .PERIOD_W (PERIOD_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .master_sel   (master_sel),
  .frame_period (frame_period),
  .in_valid     (in_valid),
  .in_bit       (in_bit),
  .smp_trig     (smp_trig),
  .out_valid    (out_valid),
  .out_bit      (out_bit),
  .overrun      (overrun)
);

// File: tb/chain_node_test.sv
module chain_node_test;

  localparam int UP_W     = 16;
  localparam int SAMPLE_W = 8;
  localparam int STOP_N   = 2;
  localparam int PERIOD_W = 16;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                master_sel = 1'b0;
  logic [PERIOD_W-1:0] frame_period = 16'd40;
  logic                in_valid = 1'b0;
  logic                in_bit = 1'b0;
  logic [SAMPLE_W-1:0] smp_data = '0;
  logic                smp_trig, out_valid, out_bit, overrun;

  chain_node #(
    .UP_W(UP_W), .SAMPLE_W(SAMPLE_W), .STOP_N(STOP_N), .PERIOD_W(PERIOD_W)
  ) uut (
    .clk(clk), .rst(rst), .master_sel(master_sel), .frame_period(frame_period),
    .in_valid(in_valid), .in_bit(in_bit), .smp_data(smp_data),
    .smp_trig(smp_trig), .out_valid(out_valid), .out_bit(out_bit), .overrun(overrun)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int trig_cnt = 0;
  int ovr_cnt = 0;
  bit obits[$];
  bit exp_q[$];
  int trig_at[$];
  bit pv, pb, fwd_chk;
  int tmis;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) obits.push_back(out_bit);
      if (smp_trig) begin
        trig_cnt++;
        trig_at.push_back(cyc);
      end
      if (overrun) ovr_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  task automatic reset_dut(input bit m, input int p);
    rst = 1'b1;
    master_sel = m;
    frame_period = PERIOD_W'(p);
    in_valid = 1'b1;
    in_bit = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !smp_trig && !overrun, "R1", "outputs during reset",
          {out_valid, smp_trig, overrun}, 0);
    in_valid = 1'b0;
    in_bit = 1'b0;
    rst = 1'b0;
    obits.delete();
    exp_q.delete();
    trig_at.delete();
    trig_cnt = 0;
    ovr_cnt = 0;
    @(negedge clk);
    check(!out_valid && !smp_trig && !overrun, "R1", "outputs after reset",
          {out_valid, smp_trig, overrun}, 0);
  endtask

  task automatic push_exp(input bit [UP_W-1:0] pay, input int plen,
                          input bit [SAMPLE_W-1:0] s, input int slen, input bit stops);
    exp_q.push_back(1'b1);
    for (int i = 0; i < plen; i++) exp_q.push_back(pay[UP_W-1-i]);
    for (int i = 0; i < slen; i++) exp_q.push_back(s[SAMPLE_W-1-i]);
    if (stops) for (int i = 0; i < STOP_N; i++) exp_q.push_back(1'b0);
  endtask

  task automatic compare_stream(input string req, input string what);
    int diff = -1;
    if (obits.size() != exp_q.size()) begin
      check(1'b0, req, {what, " length"}, obits.size(), exp_q.size());
    end else begin
      foreach (exp_q[i]) if (diff < 0 && obits[i] != exp_q[i]) diff = i;
      if (diff < 0) check(1'b1, req, what, 0, 0);
      else check(1'b0, req, $sformatf("%s bit %0d", what, diff), obits[diff], exp_q[diff]);
    end
    obits.delete();
    exp_q.delete();
  endtask

  // one negedge: check forwarded output of previous drive, then drive
  task automatic step(input bit v, input bit b, input bit next_chk);
    @(negedge clk);
    if (fwd_chk && (out_valid !== pv || (pv && out_bit !== pb))) tmis++;
    in_valid = v;
    in_bit = b;
    pv = v;
    pb = b;
    fwd_chk = next_chk;
  endtask

  task automatic send_frame(input bit [UP_W-1:0] pay, input bit [SAMPLE_W-1:0] smp,
                            input int idle_pct, input bit stop_val, input int gap);
    bit sv[$];
    bit sb[$];
    for (int i = UP_W - 1; i >= 0; i--) begin
      while ($urandom_range(99) < idle_pct) begin
        sv.push_back(1'b0);
        sb.push_back(1'($urandom));
      end
      sv.push_back(1'b1);
      sb.push_back(pay[i]);
    end
    smp_data = smp;
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = 1'b1;
    @(negedge clk);
    check(smp_trig && out_valid && out_bit, "R2", "start bit and trigger",
          {smp_trig, out_valid, out_bit}, 7);
    smp_data = SAMPLE_W'($urandom);  // R6: later changes must not matter
    tmis = 0;
    in_valid = sv[0];
    in_bit = sb[0];
    pv = sv[0];
    pb = sb[0];
    fwd_chk = 1'b1;
    for (int j = 1; j < sv.size(); j++) step(sv[j], sb[j], 1'b1);
    for (int k = 0; k < STOP_N; k++) step(1'b1, stop_val, 1'b0);
    for (int k = 0; k < gap; k++) step(1'b0, 1'($urandom), 1'b0);
    check(tmis == 0, "R3", "per-cycle forwarding", tmis, 0);
  endtask

  initial begin
    bit [UP_W-1:0] p, p2;
    bit [SAMPLE_W-1:0] s, s2;
    int n;
    void'($urandom(32'd20240611));

    // relay mode
    reset_dut(1'b0, 40);

    // R5: idle noise and valid zeros while hunting
    in_bit = 1'b1;
    repeat (20) @(negedge clk);
    in_valid = 1'b1;
    in_bit = 1'b0;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(obits.size() == 0 && trig_cnt == 0, "R5", "hunt ignores noise", obits.size(), 0);

    // directed: all-ones payload, zero sample
    send_frame('1, '0, 0, 1'b0, SAMPLE_W + STOP_N + 4);
    push_exp('1, UP_W, '0, SAMPLE_W, 1'b1);
    compare_stream("R4", "ones payload zero sample");

    // directed: zero payload, ones sample, stop slots carry ones
    send_frame('0, '1, 0, 1'b1, SAMPLE_W + STOP_N + 4);
    push_exp('0, UP_W, '1, SAMPLE_W, 1'b1);
    compare_stream("R5", "stop slots of value one");
    check(trig_cnt == 2, "R5", "no start from stop slots", trig_cnt, 2);

    // random frames with idle gaps
    n = 0;
    for (int f = 0; f < 20; f++) begin
      p = UP_W'($urandom);
      s = SAMPLE_W'($urandom);
      send_frame(p, s, 30, 1'($urandom), SAMPLE_W + STOP_N + 4);
      push_exp(p, UP_W, s, SAMPLE_W, 1'b1);
      compare_stream("R6", $sformatf("random frame %0d", f));
      n++;
    end
    check(trig_cnt == n + 2, "R9", "one trigger per frame", trig_cnt, n + 2);
    check(ovr_cnt == 0, "R8", "no overrun with room", ovr_cnt, 0);

    // R8: second start lands inside the append
    p = UP_W'($urandom);
    s = SAMPLE_W'($urandom);
    p2 = UP_W'($urandom);
    s2 = SAMPLE_W'($urandom);
    ovr_cnt = 0;
    send_frame(p, s, 0, 1'b0, 0);
    send_frame(p2, s2, 0, 1'b0, SAMPLE_W + STOP_N + 4);
    push_exp(p, UP_W, s, STOP_N, 1'b0);
    push_exp(p2, UP_W, s2, SAMPLE_W, 1'b1);
    compare_stream("R8", "truncated then full frame");
    check(ovr_cnt == 1, "R8", "overrun pulses", ovr_cnt, 1);

    // head-of-chain mode, slow period, noisy input
    reset_dut(1'b1, 40);
    for (int k = 0; k < 6; k++) begin
      s = SAMPLE_W'($urandom);
      smp_data = s;
      push_exp('0, 0, s, SAMPLE_W, 1'b1);
      do begin
        @(negedge clk);
        in_valid = 1'($urandom);
        in_bit = 1'($urandom);
      end while (!smp_trig);
    end
    repeat (20) begin
      @(negedge clk);
      in_valid = 1'($urandom);
      in_bit = 1'($urandom);
    end
    in_valid = 1'b0;
    compare_stream("R7", "head frames with input noise");
    check(trig_cnt == 6, "R9", "head trigger count", trig_cnt, 6);
    for (int k = 1; k < trig_at.size(); k++)
      check(trig_at[k] - trig_at[k-1] == 40, "R7", "frame spacing",
            trig_at[k] - trig_at[k-1], 40);
    check(ovr_cnt == 0, "R8", "head no overrun", ovr_cnt, 0);

    // head-of-chain mode, period shorter than a frame
    reset_dut(1'b1, 6);
    repeat (60) @(negedge clk);
    check(trig_cnt >= 9 && ovr_cnt == trig_cnt - 1, "R8", "short period overruns",
          ovr_cnt, trig_cnt - 1);

    summary();
  end

endmodule